// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Port

This block is one port of general-purpose I/O for a motion-control FPGA. Each of its 24 pins is configured separately for electrical mode (input-only, output-only, tristate or open-collector), logic polarity, and the source of its output: either the port's own output-data register or one of seven on-chip peripheral signals, such as a step generator or a PWM unit. Every setting is held in a bit-plane register. Bit n of each register word belongs to pin n.

A host reaches the port through a simple word-wide register bus. A write lands on the clock edge. A read is combinational from the current address. Every pad input passes through a two-flop synchronizer. After the polarity bit is applied, the input appears at the data readback and at a per-pin tap that feeds on-chip peripherals such as encoder counters. This happens in every mode. Toward the pad, each pin presents an output value and a drive enable.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset, all register planes read zero, no pad is driven (`pad_oe` all 0), and every pin is an active-high input-only GPIO pin.
- R2: Register offsets are 0 = data, 1 = output enable, 2 = mode bit 0, 3 = mode bit 1, 4/5/6 = source bits 0/1/2, 7 = polarity. Offsets 1 to 7 read back the value last written. Bits 31:24 always read 0.
- R3: A read at offset 0 returns the pad input XOR polarity. It does not reflect a pad change after one rising edge, and it does reflect the change after two rising edges.
- R4: `periph_tap` always equals the value read at offset 0, whatever the pin's mode.
- R5: With mode {bit1,bit0} = 00 (input-only), the pin's `pad_oe` is 0.
- R6: With mode 01 (output-only), `pad_oe` is 1, whatever the output-enable bit is.
- R7: With mode 10 (tristate), `pad_oe` follows the pin's output-enable bit.
- R8: With mode 11 (open-collector), `pad_out` is 0. `pad_oe` is 1 when the pad-level value is 0 and 0 when it is 1.
- R9: A source value of 0 takes the output from the data register written at offset 0. A source value s in 1 to 7 takes it from `periph_out[n*7 + s-1]` only.
- R10: The pad-level value is the selected source XOR the polarity bit. In modes 00, 01 and 10, `pad_out` carries this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 24 | Raw pad inputs |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad drive enables |
| periph_out | input | 168 | Peripheral outputs, 7 per pin, pin n at bits n*7 +: 7 |
| periph_tap | output | 24 | Synchronized, polarity-corrected inputs for peripherals |

## Verification
The pad outputs depend only on the registers and on `periph_out`. They are due in the same clock phase that follows the write edge, or at once after a peripheral change. The bench therefore samples them on the falling edge after each write. The input path carries two flop stages. The bench changes `pad_in`, confirms that readback still shows the old value one rising edge later, and confirms the new value after the second edge. Register readback and `periph_tap` are combinational from the address and state, so they are sampled one time step after the address is set.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PINS     = 24;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int SRC_W    = 3;
    localparam int PERIPH_N = (1 << SRC_W) - 1;

    typedef enum logic [1:0] {
        MODE_IN  = 2'b00,
        MODE_OUT = 2'b01,
        MODE_TRI = 2'b10,
        MODE_OC  = 2'b11
    } pin_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_OE    = 3'd1,
        OFS_MODE0 = 3'd2,
        OFS_MODE1 = 3'd3,
        OFS_SRC0  = 3'd4,
        OFS_SRC1  = 3'd5,
        OFS_SRC2  = 3'd6,
        OFS_POL   = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        pin_mode_e         mode;
        logic [SRC_W-1:0]  src;
        logic              pol;
        logic              oe;
        logic              dout;
    } pin_cfg_t;

    // Pad-level value from the selected source and the polarity bit.
    function automatic logic pad_level(logic sel_val, logic pol);
        return sel_val ^ pol;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int N  = PINS,
    parameter int BW = BUS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BW-1:0]       wdata,
    input  logic [N-1:0]        in_logical,
    output logic [BW-1:0]       rdata,
    output pin_cfg_t [N-1:0]    cfg
);

    logic [N-1:0] dout_q, oe_q, m0_q, m1_q, pol_q;
    logic [SRC_W-1:0][N-1:0] src_q;
    logic [N-1:0] rd_plane;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            oe_q   <= '0;
            m0_q   <= '0;
            m1_q   <= '0;
            pol_q  <= '0;
            src_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_DATA:  dout_q   <= wdata[N-1:0];
                OFS_OE:    oe_q     <= wdata[N-1:0];
                OFS_MODE0: m0_q     <= wdata[N-1:0];
                OFS_MODE1: m1_q     <= wdata[N-1:0];
                OFS_SRC0:  src_q[0] <= wdata[N-1:0];
                OFS_SRC1:  src_q[1] <= wdata[N-1:0];
                OFS_SRC2:  src_q[2] <= wdata[N-1:0];
                OFS_POL:   pol_q    <= wdata[N-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_DATA:  rd_plane = in_logical;
            OFS_OE:    rd_plane = oe_q;
            OFS_MODE0: rd_plane = m0_q;
            OFS_MODE1: rd_plane = m1_q;
            OFS_SRC0:  rd_plane = src_q[0];
            OFS_SRC1:  rd_plane = src_q[1];
            OFS_SRC2:  rd_plane = src_q[2];
            default:   rd_plane = pol_q;
        endcase
        rdata = BW'(rd_plane);
    end

    always_comb begin
        for (int n = 0; n < N; n++) begin
            cfg[n].mode = pin_mode_e'({m1_q[n], m0_q[n]});
            for (int s = 0; s < SRC_W; s++) cfg[n].src[s] = src_q[s][n];
            cfg[n].pol  = pol_q[n];
            cfg[n].oe   = oe_q[n];
            cfg[n].dout = dout_q[n];
        end
    end

    // R2: a polarity write lands on the edge that takes it
    a_r2_pol_write_lands: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(addr) == OFS_POL)
            |-> pol_q == $past(wdata[N-1:0]));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int N = gpio_port_pkg::PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] pol,
    output logic [N-1:0] in_logical
);

    logic [N-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    assign in_logical = sync_q ^ pol;

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  pin_cfg_t            cfg,
    input  logic [PERIPH_N-1:0] periph,
    output logic                pad_out,
    output logic                pad_oe
);

    logic sel_val, lvl;

    always_comb begin
        if (cfg.src == '0) sel_val = cfg.dout;
        else               sel_val = periph[int'(cfg.src) - 1];
        lvl = pad_level(sel_val, cfg.pol);
        case (cfg.mode)
            MODE_IN:  begin pad_out = lvl;  pad_oe = 1'b0;   end
            MODE_OUT: begin pad_out = lvl;  pad_oe = 1'b1;   end
            MODE_TRI: begin pad_out = lvl;  pad_oe = cfg.oe; end
            default:  begin pad_out = 1'b0; pad_oe = ~lvl;   end
        endcase
    end

    // R5: input-only never drives
    a_r5_input_released: assert property (@(posedge clk) disable iff (rst)
        cfg.mode == MODE_IN |-> !pad_oe);
    // R6: output-only always drives
    a_r6_output_drives: assert property (@(posedge clk) disable iff (rst)
        cfg.mode == MODE_OUT |-> pad_oe);
    // R8: open-collector never drives high
    a_r8_oc_never_high: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_OC && pad_oe) |-> !pad_out);
    // R9: with source 0 the register bit reaches the pad
    a_r9_gpio_source: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_OUT && cfg.src == '0) |-> pad_out == (cfg.dout ^ cfg.pol));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = PINS,
    parameter int DATA_W   = BUS_W,
    localparam int PW      = NUM_PINS * PERIPH_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [PW-1:0]       periph_out,
    output logic [NUM_PINS-1:0] periph_tap
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0] pol_vec;
    logic [NUM_PINS-1:0] in_logical;

    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) pol_vec[n] = cfg[n].pol;
    end

    gpio_port_sync #(.N(NUM_PINS)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pad_in     (pad_in),
        .pol        (pol_vec),
        .in_logical (in_logical)
    );

    gpio_port_regs #(.N(NUM_PINS), .BW(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .in_logical (in_logical),
        .rdata      (bus_rdata),
        .cfg        (cfg)
    );

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            gpio_port_pin u_pin (
                .clk     (clk),
                .rst     (rst),
                .cfg     (cfg[n]),
                .periph  (periph_out[n*PERIPH_N +: PERIPH_N]),
                .pad_out (pad_out[n]),
                .pad_oe  (pad_oe[n])
            );
        end
    endgenerate

    assign periph_tap = in_logical;

    // R4: tap and data readback agree
    a_r4_tap_matches_read: assert property (@(posedge clk) disable iff (rst)
        bus_addr == OFS_DATA |-> bus_rdata[NUM_PINS-1:0] == periph_tap);
    // R2: unused read bits stay zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int N  = 24;
    localparam int PN = 7;

    logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pad_in = '0, pad_out, pad_oe, periph_tap;
    logic [N*PN-1:0] periph_out = '0;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
        .periph_tap(periph_tap)
    );

    // {mode[1:0], src[2:0], pol, oe, gpio_bit, periph_bit, exp_out, exp_oe}
    localparam logic [10:0] VEC [12] = '{
        11'b00_000_0_1_1_0_1_0,  // R5 input-only released
        11'b01_000_0_0_1_0_1_1,  // R6 R9 output-only from register
        11'b01_000_1_0_1_0_0_1,  // R10 polarity inverts
        11'b10_000_0_0_1_0_1_0,  // R7 tristate, enable low
        11'b10_000_0_1_0_0_0_1,  // R7 tristate, enable high
        11'b11_000_0_0_0_0_0_1,  // R8 OC pulls low
        11'b11_000_0_0_1_0_0_0,  // R8 OC releases
        11'b11_000_1_0_1_0_0_1,  // R8 R10 OC inverted
        11'b01_001_0_0_0_1_1_1,  // R9 source 1
        11'b01_111_0_0_1_0_0_1,  // R9 source 7
        11'b01_011_1_0_0_0_1_1,  // R9 R10 source 3 inverted
        11'b10_101_0_1_0_1_1_1   // R7 R9 source 5 tristate
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    function automatic logic [N*PN-1:0] mk_periph(int s, logic v);
        logic [N*PN-1:0] p;
        for (int n = 0; n < N; n++)
            for (int k = 0; k < PN; k++)
                p[n*PN+k] = (k == s - 1) ? v : ~v;
        return p;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        for (int a = 1; a < 8; a++) rd_check("R1 plane", 3'(a), 32'h0);

        // table walk over modes, sources and polarity
        foreach (VEC[i]) begin
            logic [10:0] v;
            v = VEC[i];
            wr(3'd2, {32{v[9]}});
            wr(3'd3, {32{v[10]}});
            wr(3'd4, {32{v[6]}});
            wr(3'd5, {32{v[7]}});
            wr(3'd6, {32{v[8]}});
            wr(3'd7, {32{v[5]}});
            wr(3'd1, {32{v[4]}});
            wr(3'd0, {32{v[3]}});
            periph_out = mk_periph(int'(v[8:6]), v[2]);
            #1;
            check($sformatf("R5-R10 vec%0d out", i), 32'(pad_out), {8'h0, {N{v[1]}}});
            check($sformatf("R5-R10 vec%0d oe", i),  32'(pad_oe),  {8'h0, {N{v[0]}}});
        end

        // R2 readback of planes, upper bits zero
        for (int a = 1; a < 8; a++) begin
            wr(3'(a), 32'hFFFF_0000 | 32'(a * 32'h111));
            rd_check("R2 readback", 3'(a), 32'h00FF_0000 | 32'(a * 32'h111));
        end

        // R3 synchronizer latency, polarity clear, mode output-only (R4)
        wr(3'd7, 32'h0);
        wr(3'd2, 32'hFFFFFF);
        wr(3'd3, 32'h0);
        @(negedge clk);
        pad_in = 24'hA5A5A5;
        bus_addr = 3'd0;
        @(negedge clk);
        rd_check("R3 one edge", 3'd0, 32'h0);
        @(negedge clk);
        rd_check("R3 two edges", 3'd0, 32'h00A5A5A5);
        check("R4 tap output mode", 32'(periph_tap), 32'h00A5A5A5);

        // R3 polarity on input path
        wr(3'd7, 32'h00FFFF);
        rd_check("R3 polarity", 3'd0, 32'h00A55A5A);

        // R4 tap in open-collector mode
        wr(3'd3, 32'hFFFFFF);
        #1;
        check("R4 tap oc mode", 32'(periph_tap), 32'h00A55A5A);

        // R1 reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1 pol after reset", 3'd7, 32'h0);
        check("R1 oe after reset", 32'(pad_oe), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule